// File: doc/BRIEF.md
# Stereo I2S Master Transmitter with Register Bus

This block sends a stream of stereo samples out as a serial audio link in which it is the clock master. Software writes each sample pair over a simple 32-bit register bus. The left sample goes into a holding register first. Writing the right sample then pushes the whole pair into an eight-entry transmit FIFO. The serializer makes the bit clock by dividing the system clock. It drives the word-select line and sends each sample MSB first, with the data one bit clock behind the word-select change as standard I2S timing requires.

Four enables must all be 1 before any bit clock appears: a global enable, a transmit-block enable, a channel enable and a clock enable. The word-select half-period (16, 24 or 32 bit clocks) is set apart from the sample resolution (16, 24 or 32 bits). A resolution shorter than the slot is padded with trailing zeros. A resolution longer than the slot is cut to its most significant bits. A programmable fill threshold flags the FIFO as nearly empty. A push into a full FIFO is dropped and flagged as an overrun. Each of the two flags can be masked from the interrupt line.

Top module: `i2s_tx_regbus`

## Requirements
- R1: After reset all registers read 0 except the interrupt mask, which reads 0x30. Status reads 0x10 (the FIFO is empty). `sck_o`, `ws_o`, `sd_o` and `irq_o` are 0.
- R2: The bit clock runs only while bit 0 of each of these registers is 1: global enable (0x000), transmit-block enable (0x008), clock enable (0x00C) and channel enable (0x02C). Otherwise `sck_o`, `ws_o` and `sd_o` stay 0 and the FIFO is not read.
- R3: `sck_o` toggles every CLK_DIV system clocks. Each word-select half-period lasts WL bit clocks. WL is set by bits [4:3] of register 0x010: code 0 gives 16, code 1 gives 24, and codes 2 and 3 give 32.
- R4: `ws_o` is 0 for the left sample and 1 for the right sample. `ws_o` and `sd_o` change only when `sck_o` falls. The MSB of each sample follows its `ws_o` change by one bit clock.
- R5: Register 0x034 bits [2:0] set the resolution: code 2 gives 16 bits, code 4 gives 24 bits, code 5 gives 32 bits, and any other code gives 16 bits. Samples are written right-aligned and sent MSB first. Slots past the resolution carry 0. A resolution above WL sends only the top WL bits.
- R6: A write to 0x020 stores the left sample. A write to 0x024 pushes {left, right} into the FIFO, which holds FIFO_DEPTH (default 8) pairs. Pairs are sent in the order they were pushed.
- R7: A push while the FIFO is full drops the pair and sets status bit 5 (overrun). Any write to 0x044 clears that bit.
- R8: Status bit 4 (empty) is 1 exactly when the FIFO fill level is at or below the threshold in register 0x04C bits [3:0].
- R9: `irq_o` is the OR of status bit 4 gated by mask bit 4 being 0 and status bit 5 gated by mask bit 5 being 0. The mask is register 0x03C.
- R10: Writing 1 in bit 0 of either register 0x018 or register 0x054 empties the FIFO.
- R11: When the serializer needs a pair and the FIFO is empty, it sends an all-zero frame.
- R12: Clearing the global enable stops `sck_o` and returns word select and data to 0. Every configuration register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| sck_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word select (0 left, 1 right) |
| sd_o | output | 1 | Serial data |
| irq_o | output | 1 | Interrupt request |

## Verification
The embedded properties check several rules on every cycle. Bit clock, word select and data are quiet whenever the enables are not all set. Word select moves only on a falling bit clock. The FIFO level stays within its depth, and a flush always leaves it empty. A push into a full FIFO always raises the overrun flag and leaves the level unchanged.

Other behaviour shows only in the bench's scenarios, which decode the serial line and compare each recovered word with a scoreboard. These cover bit ordering, zero padding and truncation for each pairing of resolution and word length, zero frames on underflow, the dropped ninth pair, the threshold edges, the interrupt masking, and registers that survive a global disable.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
   // register byte offsets (software visible map)
   localparam logic [11:0] OFF_TOP_EN   = 12'h000;
   localparam logic [11:0] OFF_BLK_EN   = 12'h008;
   localparam logic [11:0] OFF_CLK_EN   = 12'h00C;
   localparam logic [11:0] OFF_CLK_CFG  = 12'h010;
   localparam logic [11:0] OFF_FLUSH    = 12'h018;
   localparam logic [11:0] OFF_LEFT     = 12'h020;
   localparam logic [11:0] OFF_RIGHT    = 12'h024;
   localparam logic [11:0] OFF_CH_EN    = 12'h02C;
   localparam logic [11:0] OFF_RES      = 12'h034;
   localparam logic [11:0] OFF_STAT     = 12'h038;
   localparam logic [11:0] OFF_MASK     = 12'h03C;
   localparam logic [11:0] OFF_OVR_CLR  = 12'h044;
   localparam logic [11:0] OFF_THR      = 12'h04C;
   localparam logic [11:0] OFF_CH_FLUSH = 12'h054;

   localparam int SAMPLE_W  = 32;
   localparam int BIT_EMPTY = 4;
   localparam int BIT_OVR   = 5;

   // word-select half-period in bit clocks
   function automatic logic [6:0] slot_len(input logic [1:0] code);
      case (code)
         2'd0:    slot_len = 7'd16;
         2'd1:    slot_len = 7'd24;
         default: slot_len = 7'd32;
      endcase
   endfunction

   // number of significant sample bits
   function automatic logic [6:0] res_len(input logic [2:0] code);
      case (code)
         3'd4:    res_len = 7'd24;
         3'd5:    res_len = 7'd32;
         default: res_len = 7'd16;
      endcase
   endfunction
endpackage

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo #(
   parameter int DEPTH = 8,
   parameter int W     = 64,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   input  logic          flush,
   output logic [W-1:0]  dout,
   output logic          full,
   output logic          empty,
   output logic [LW-1:0] level
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          do_push, do_pop;

   assign full    = (level == LW'(DEPTH));
   assign empty   = (level == '0);
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   a_r6_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(DEPTH));

   a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (level == '0));

   a_r7_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> $stable(level));
endmodule

// File: rtl/i2s_tx_regs.sv
module i2s_tx_regs
   import i2s_tx_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int LW     = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_we,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [SAMPLE_W-1:0]   bus_wdata,
   output logic [SAMPLE_W-1:0]   bus_rdata,
   input  logic                  fifo_full,
   input  logic [LW-1:0]         fifo_level,
   output logic                  push,
   output logic [2*SAMPLE_W-1:0] push_data,
   output logic                  flush,
   output logic                  run,
   output logic [1:0]            wl_code,
   output logic [2:0]            res_code,
   output logic                  irq
);
   logic                top_en, blk_en, clk_en, ch_en, ovr_q;
   logic [1:0]          mask_q;
   logic [LW-1:0]       thr_q;
   logic [SAMPLE_W-1:0] left_q;
   logic                empty_st;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [11:0] off);
      hit = (a == ADDR_W'(off));
   endfunction

   assign push      = bus_we && hit(bus_addr, OFF_RIGHT);
   assign push_data = {left_q, bus_wdata};
   assign flush     = bus_we && bus_wdata[0] &&
                      (hit(bus_addr, OFF_FLUSH) || hit(bus_addr, OFF_CH_FLUSH));
   assign run       = top_en && blk_en && ch_en && clk_en;
   assign empty_st  = (fifo_level <= thr_q);
   assign irq       = (empty_st && !mask_q[0]) || (ovr_q && !mask_q[1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         top_en   <= 1'b0;
         blk_en   <= 1'b0;
         clk_en   <= 1'b0;
         ch_en    <= 1'b0;
         wl_code  <= '0;
         res_code <= '0;
         mask_q   <= 2'b11;
         thr_q    <= '0;
         left_q   <= '0;
      end else if (bus_we) begin
         if (hit(bus_addr, OFF_TOP_EN))  top_en   <= bus_wdata[0];
         if (hit(bus_addr, OFF_BLK_EN))  blk_en   <= bus_wdata[0];
         if (hit(bus_addr, OFF_CLK_EN))  clk_en   <= bus_wdata[0];
         if (hit(bus_addr, OFF_CH_EN))   ch_en    <= bus_wdata[0];
         if (hit(bus_addr, OFF_CLK_CFG)) wl_code  <= bus_wdata[4:3];
         if (hit(bus_addr, OFF_RES))     res_code <= bus_wdata[2:0];
         if (hit(bus_addr, OFF_MASK))    mask_q   <= bus_wdata[BIT_OVR:BIT_EMPTY];
         if (hit(bus_addr, OFF_THR))     thr_q    <= bus_wdata[LW-1:0];
         if (hit(bus_addr, OFF_LEFT))    left_q   <= bus_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                ovr_q <= 1'b0;
      else if (push && fifo_full)                ovr_q <= 1'b1;
      else if (bus_we && hit(bus_addr, OFF_OVR_CLR)) ovr_q <= 1'b0;
   end

   always_comb begin
      bus_rdata = '0;
      if      (hit(bus_addr, OFF_TOP_EN))  bus_rdata[0] = top_en;
      else if (hit(bus_addr, OFF_BLK_EN))  bus_rdata[0] = blk_en;
      else if (hit(bus_addr, OFF_CLK_EN))  bus_rdata[0] = clk_en;
      else if (hit(bus_addr, OFF_CH_EN))   bus_rdata[0] = ch_en;
      else if (hit(bus_addr, OFF_CLK_CFG)) bus_rdata[4:3] = wl_code;
      else if (hit(bus_addr, OFF_RES))     bus_rdata[2:0] = res_code;
      else if (hit(bus_addr, OFF_LEFT))    bus_rdata = left_q;
      else if (hit(bus_addr, OFF_MASK))    bus_rdata[BIT_OVR:BIT_EMPTY] = mask_q;
      else if (hit(bus_addr, OFF_THR))     bus_rdata[LW-1:0] = thr_q;
      else if (hit(bus_addr, OFF_STAT)) begin
         bus_rdata[BIT_EMPTY] = empty_st;
         bus_rdata[BIT_OVR]   = ovr_q;
      end
   end

   a_r7_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (push && fifo_full) |=> ovr_q);

   a_r7_overrun_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && hit(bus_addr, OFF_OVR_CLR)) |=> !ovr_q);
endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
   import i2s_tx_pkg::*;
#(
   parameter int CLK_DIV = 2,
   localparam int CW     = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  run,
   input  logic [1:0]            wl_code,
   input  logic [2:0]            res_code,
   input  logic                  fifo_empty,
   input  logic [2*SAMPLE_W-1:0] fifo_dout,
   output logic                  pop,
   output logic                  sck_o,
   output logic                  ws_o,
   output logic                  sd_o
);
   logic                tick, sck_q;
   logic [6:0]          slot, wl, res, last_slot, j, k;
   logic [SAMPLE_W-1:0] cur_l, cur_r, word;
   logic [4:0]          idx;
   logic                is_r;

   generate
      if (CLK_DIV == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        cnt <= '0;
            else if (!run)                     cnt <= '0;
            else if (cnt == CW'(CLK_DIV - 1))  cnt <= '0;
            else                               cnt <= cnt + 1'b1;
         end
         assign tick = (cnt == CW'(CLK_DIV - 1));
      end
   endgenerate

   assign wl        = slot_len(wl_code);
   assign res       = res_len(res_code);
   assign last_slot = (wl << 1) - 7'd1;
   assign pop       = run && tick && sck_q && (slot == '0) && !fifo_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;
         slot  <= '0;
         cur_l <= '0;
         cur_r <= '0;
      end else if (!run) begin
         sck_q <= 1'b0;
         slot  <= '0;
         cur_l <= '0;
         cur_r <= '0;
      end else if (tick) begin
         sck_q <= ~sck_q;
         if (sck_q) begin
            slot <= (slot >= last_slot) ? 7'd0 : slot + 7'd1;
            if (slot == '0) begin
               cur_l <= fifo_empty ? '0 : fifo_dout[2*SAMPLE_W-1:SAMPLE_W];
               cur_r <= fifo_empty ? '0 : fifo_dout[SAMPLE_W-1:0];
            end
         end
      end
   end

   // slot 0 carries the last bit of the previous right word
   always_comb begin
      j    = (slot == '0) ? last_slot : slot - 7'd1;
      is_r = (j >= wl);
      k    = is_r ? j - wl : j;
      word = is_r ? cur_r : cur_l;
      idx  = 5'(res - 7'd1 - k);
      sd_o = (k < res) ? word[idx] : 1'b0;
   end

   assign ws_o  = (slot >= wl);
   assign sck_o = sck_q;

   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!sck_o && !ws_o && !sd_o));

   a_r4_ws_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && !$stable(ws_o)) |-> $fell(sck_o));

   a_r4_sd_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && $rose(sck_o)) |-> $stable(sd_o));
endmodule

// File: rtl/i2s_tx_regbus.sv
module i2s_tx_regbus
   import i2s_tx_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int CLK_DIV    = 2,
   parameter int FIFO_DEPTH = 8,
   localparam int LW        = $clog2(FIFO_DEPTH) + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [SAMPLE_W-1:0] bus_wdata,
   output logic [SAMPLE_W-1:0] bus_rdata,
   output logic                sck_o,
   output logic                ws_o,
   output logic                sd_o,
   output logic                irq_o
);
   generate
      if (CLK_DIV < 1) begin : g_bad_div
         $error("CLK_DIV must be at least 1");
      end
      if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("FIFO_DEPTH must be a power of two of at least 2");
      end
      if (ADDR_W < 7 || ADDR_W > 12) begin : g_bad_addr
         $error("ADDR_W must lie between 7 and 12");
      end
      if (LW > SAMPLE_W) begin : g_bad_lw
         $error("FIFO_DEPTH too large for threshold field");
      end
   endgenerate

   logic                  push, flush, run, pop, full, empty;
   logic [2*SAMPLE_W-1:0] push_data, dout;
   logic [LW-1:0]         level;
   logic [1:0]            wl_code;
   logic [2:0]            res_code;

   i2s_tx_regs #(.ADDR_W(ADDR_W), .LW(LW)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fifo_full(full),
      .fifo_level(level), .push(push), .push_data(push_data), .flush(flush),
      .run(run), .wl_code(wl_code), .res_code(res_code), .irq(irq_o)
   );

   i2s_tx_fifo #(.DEPTH(FIFO_DEPTH), .W(2*SAMPLE_W)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .din(push_data), .pop(pop),
      .flush(flush), .dout(dout), .full(full), .empty(empty), .level(level)
   );

   i2s_tx_serializer #(.CLK_DIV(CLK_DIV)) u_ser (
      .clk(clk), .rst_n(rst_n), .run(run), .wl_code(wl_code),
      .res_code(res_code), .fifo_empty(empty), .fifo_dout(dout), .pop(pop),
      .sck_o(sck_o), .ws_o(ws_o), .sd_o(sd_o)
   );
endmodule

// File: tb/test_i2s_tx_regbus.sv
module test_i2s_tx_regbus;
   localparam int DIV = 2;

   logic        clk = 0, rst_n = 0, bus_we = 0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic        sck_o, ws_o, sd_o, irq_o;

   int checks = 0, errors = 0;
   bit done = 0;

   i2s_tx_regbus #(.ADDR_W(12), .CLK_DIV(DIV), .FIFO_DEPTH(8)) i_i2s_tx_regbus (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_o(sck_o),
      .ws_o(ws_o), .sd_o(sd_o), .irq_o(irq_o)
   );

   always #10 clk = ~clk;

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // scoreboard and monitor
   logic [31:0] exp_q[$];
   bit          mon_arm = 0;
   int          mon_wl = 32;
   int          rise_cnt = 0, cyc = 0, last_rise = 0, last_period = 0;
   logic [63:0] acc = '0;
   logic        prev_ws = 0, prev_sck = 0;
   int          nbits = 0;

   always @(negedge clk) begin
      logic [31:0] act, exp;
      cyc++;
      if (sck_o && !prev_sck) begin
         rise_cnt++;
         last_period = cyc - last_rise;
         last_rise = cyc;
      end
      if (!mon_arm) begin
         acc = '0; prev_ws = 0; nbits = 0;
      end else if (sck_o && !prev_sck) begin
         acc = {acc[62:0], sd_o};
         nbits++;
         if (ws_o != prev_ws) begin
            act = 32'(acc & ((64'd1 << mon_wl) - 64'd1));
            if (prev_ws) check("R3 right word bit count", 32'(nbits), 32'(mon_wl));
            if (exp_q.size() > 0) begin
               exp = exp_q.pop_front();
               check("R6 R5 R4 serial word", act, exp);
            end else begin
               check("R11 underflow zero word", act, 32'h0);
            end
            acc = '0; nbits = 0; prev_ws = ws_o;
         end
      end
      prev_sck = sck_o;
   end

   initial begin
      int lim;
      lim = 180000;
      repeat (lim) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic bus_wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1;
      @(negedge clk);
      bus_we = 0;
   endtask

   task automatic bus_rd(logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   function automatic logic [31:0] exp_word(logic [31:0] s, int res, int wl);
      logic [31:0] w = '0;
      for (int k = 0; k < wl; k++) if (k < res) w[wl-1-k] = s[res-1-k];
      return w;
   endfunction

   function automatic int wl_of(int code);
      return (code == 0) ? 16 : (code == 1) ? 24 : 32;
   endfunction

   function automatic int res_of(int code);
      return (code == 4) ? 24 : (code == 5) ? 32 : 16;
   endfunction

   task automatic push_pair(logic [31:0] l, logic [31:0] r, int rc, int wc, bit expect_out);
      bus_wr(12'h020, l);
      bus_wr(12'h024, r);
      if (expect_out) begin
         exp_q.push_back(exp_word(l, res_of(rc), wl_of(wc)));
         exp_q.push_back(exp_word(r, res_of(rc), wl_of(wc)));
      end
   endtask

   task automatic cfg(int wc, int rc);
      bus_wr(12'h000, 0);
      mon_arm = 0;
      bus_wr(12'h018, 1);
      bus_wr(12'h010, 32'(wc) << 3);
      bus_wr(12'h034, 32'(rc));
      mon_wl = wl_of(wc);
   endtask

   task automatic start_all();
      bus_wr(12'h008, 1);
      bus_wr(12'h02C, 1);
      bus_wr(12'h00C, 1);
      mon_arm = 1;
      bus_wr(12'h000, 1);
   endtask

   task automatic drain_stop();
      int g = 0;
      while (exp_q.size() > 0 && g < 20000) begin @(negedge clk); g++; end
      check("R6 scoreboard drained", 32'(exp_q.size()), 32'd0);
      repeat (3 * 4 * mon_wl * DIV) @(negedge clk);
      mon_arm = 0;
      bus_wr(12'h000, 0);
      exp_q.delete();
   endtask

   initial begin
      logic [31:0] d;
      int r0;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 reset state
      check("R1 sck", 32'(sck_o), 0);
      check("R1 ws/sd", 32'({ws_o, sd_o}), 0);
      check("R1 irq", 32'(irq_o), 0);
      bus_rd(12'h03C, d); check("R1 mask", d, 32'h30);
      bus_rd(12'h038, d); check("R1 status", d, 32'h10);
      bus_rd(12'h000, d); check("R1 global enable", d, 0);
      bus_rd(12'h010, d); check("R1 clock cfg", d, 0);

      // R2: three enables set, clock enable off -> no activity, FIFO untouched
      cfg(2, 5);
      push_pair(32'h89ABCDEF, 32'h13579BDF, 5, 2, 1);
      bus_wr(12'h008, 1);
      bus_wr(12'h02C, 1);
      bus_wr(12'h000, 1);
      r0 = rise_cnt;
      repeat (300) @(negedge clk);
      check("R2 no bit clock", 32'(rise_cnt - r0), 0);
      check("R2 ws/sd quiet", 32'({ws_o, sd_o}), 0);
      bus_rd(12'h038, d); check("R2 FIFO not read", d & 32'h10, 0);
      // now enable clock: 32-bit samples in 32-bit slots
      mon_arm = 1;
      bus_wr(12'h00C, 1);
      push_pair(32'hF0E1D2C3, 32'h00000001, 5, 2, 1);
      push_pair(32'h80000000, 32'h7FFFFFFF, 5, 2, 1);
      repeat (40) @(negedge clk);
      check("R3 bit clock period", 32'(last_period), 32'(2 * DIV));
      drain_stop();

      // R5 16-bit in 16-bit slots
      cfg(0, 2);
      push_pair(32'h0000A5C3, 32'h00003C5A, 2, 0, 1);
      push_pair(32'hFFFF8001, 32'h00007FFE, 2, 0, 1);
      start_all();
      drain_stop();

      // R5 24-bit in 32-bit slots: padded
      cfg(2, 4);
      push_pair(32'h00F0F0F1, 32'h00800003, 4, 2, 1);
      start_all();
      drain_stop();

      // R5 32-bit in 24-bit slots: truncated to top bits
      cfg(1, 5);
      push_pair(32'hDEADBEEF, 32'hCAFEF00D, 5, 1, 1);
      start_all();
      drain_stop();

      // R5 undefined resolution code 7 -> 16 bits, 32-bit slots
      cfg(2, 7);
      push_pair(32'h1234B00C, 32'h0000FACE, 7, 2, 1);
      start_all();
      drain_stop();

      // R7 overrun: ninth pair dropped
      cfg(2, 5);
      bus_wr(12'h03C, 32'h10);
      for (int i = 0; i < 8; i++)
         push_pair(32'h01010101 * (i + 1), 32'hA0000000 + i, 5, 2, 1);
      check("R7 no overrun while filling", 32'(irq_o), 0);
      push_pair(32'h55555555, 32'hAAAAAAAA, 5, 2, 0);
      bus_rd(12'h038, d); check("R7 overrun status", d & 32'h20, 32'h20);
      check("R9 overrun irq unmasked", 32'(irq_o), 1);
      bus_wr(12'h03C, 32'h30);
      check("R9 overrun irq masked", 32'(irq_o), 0);
      bus_wr(12'h03C, 32'h10);
      bus_wr(12'h044, 0);
      bus_rd(12'h038, d); check("R7 overrun cleared", d & 32'h20, 0);
      check("R9 irq after clear", 32'(irq_o), 0);
      start_all();
      drain_stop();

      // R8 threshold
      cfg(2, 5);
      bus_wr(12'h04C, 2);
      bus_wr(12'h03C, 32'h20);
      for (int n = 0; n < 4; n++) begin
         bus_rd(12'h038, d);
         check("R8 empty at level", d & 32'h10, (n <= 2) ? 32'h10 : 0);
         check("R9 empty irq", 32'(irq_o), (n <= 2) ? 1 : 0);
         push_pair(32'h1111 * (n + 1), 32'h2222, 5, 2, 0);
      end
      bus_rd(12'h04C, d); check("R8 threshold readback", d, 2);

      // R10 flush via both registers
      bus_wr(12'h04C, 0);
      bus_wr(12'h018, 1);
      bus_rd(12'h038, d); check("R10 flush 0x018", d & 32'h10, 32'h10);
      push_pair(32'h9999, 32'h8888, 5, 2, 0);
      bus_rd(12'h038, d); check("R10 level after push", d & 32'h10, 0);
      bus_wr(12'h054, 1);
      bus_rd(12'h038, d); check("R10 flush 0x054", d & 32'h10, 32'h10);
      start_all();      // only zero words expected (R11)
      drain_stop();

      // R12 global disable mid-frame
      cfg(2, 5);
      bus_wr(12'h04C, 3);
      bus_wr(12'h03C, 32'h10);
      start_all();
      repeat (101) @(negedge clk);
      mon_arm = 0;
      bus_wr(12'h000, 0);
      repeat (2) @(negedge clk);
      r0 = rise_cnt;
      check("R12 sck stopped", 32'(sck_o), 0);
      check("R12 ws/sd reset", 32'({ws_o, sd_o}), 0);
      repeat (50) @(negedge clk);
      check("R12 no clock edges", 32'(rise_cnt - r0), 0);
      bus_rd(12'h010, d); check("R12 clock cfg kept", d, 32'h10);
      bus_rd(12'h034, d); check("R12 resolution kept", d, 5);
      bus_rd(12'h04C, d); check("R12 threshold kept", d, 3);
      bus_rd(12'h03C, d); check("R12 mask kept", d, 32'h10);
      bus_rd(12'h00C, d); check("R12 clock enable kept", d, 1);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule